// File: doc/BRIEF.md
# Torque-Count Stall Detector

This block decides whether a stepper motor has stalled from a stream of raw torque samples. The sample source delivers one sample per electrical half-cycle together with a strobe. The detector keeps the four most recent samples and averages them. It can scale small averages up by eight, and it holds the result in a torque count register.

At each current zero crossing, the block compares that register against a programmable threshold. A count below the threshold latches the stall status. The status bits stay set until a clear pulse arrives. An active-low fault pin can report the stall or stay quiet, under a report control.

Detection runs only when all four of these hold: the serial-control mode is selected, the ripple-control decay code is chosen, stall detection is enabled, and no other fault is present. At every other time the sample window is emptied.

Top module: `stall_detector`

## Requirements
- R1: Detection is active only while `mode_sel_i` is 1, `decay_sel_i` equals 3'b111, `stall_en_i` is 1 and `fault_present_i` is 0. While inactive, zero-crossing strobes latch no stall and half-cycle strobes leave `trq_count_o` unchanged.
- R2: The average is the truncated sum of the four most recent samples divided by four. Slots not yet filled since the window was last emptied count as zero.
- R3: `trq_count_o` changes only on the clock edge that samples an active half-cycle strobe, so the new value is visible the cycle after that strobe. At all other times it holds.
- R4: With `scale_en_i` at 1 and an average below 500, the count is the average times 8. With `scale_en_i` at 0, or an average of 500 or more, the count equals the average.
- R5: A scaled value above 2047 (the largest 11-bit value) saturates at 2047 and does not wrap.
- R6: A stall is latched on the edge that samples an active zero-crossing strobe, and only when the count held in that cycle is strictly below `stall_thr_i`. A count equal to the threshold latches nothing, and a count below the threshold without a strobe latches nothing.
- R7: A latched stall sets `stall_o`, `stl_o` and `fault_o` together. All three stay at 1 until cleared, whatever the count does afterwards.
- R8: `nfault_o` is 0 while a stall is latched and `report_en_i` is 1. With `report_en_i` at 0 it stays 1 even while the status bits are set.
- R9: A pulse on either `clr_reg_i` or `clr_sleep_i` clears all three status bits and releases `nfault_o` on the next edge. A clear wins over a stall detected on the same edge.
- R10: Whenever detection is inactive, the sample window is emptied to zero. The count register itself keeps its value.
- R11: After reset, `trq_count_o` is 0, all status bits are 0 and `nfault_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| raw_sample_i | input | 10 | Raw torque sample for the current half-cycle |
| half_cycle_stb_i | input | 1 | One-cycle strobe: a new sample is valid |
| zero_cross_stb_i | input | 1 | One-cycle strobe at the half-cycle current zero crossing |
| mode_sel_i | input | 1 | Serial-control mode select (1 enables detection) |
| decay_sel_i | input | 3 | Decay code; only 3'b111 allows detection |
| stall_en_i | input | 1 | Stall detection enable |
| fault_present_i | input | 1 | Another fault is present; blocks detection |
| stall_thr_i | input | 11 | Stall threshold |
| scale_en_i | input | 1 | Multiply averages below 500 by eight |
| report_en_i | input | 1 | Drive the fault pin on a stall |
| clr_reg_i | input | 1 | Clear pulse from the control register |
| clr_sleep_i | input | 1 | Clear pulse from the sleep reset pulse |
| trq_count_o | output | 11 | Torque count register |
| stall_o | output | 1 | Latched stall status |
| stl_o | output | 1 | Latched stall diagnostic bit |
| fault_o | output | 1 | Latched summary fault bit |
| nfault_o | output | 1 | Active-low fault pin |

## Verification
The assertions check the following on every cycle:
- the count holds except after an active half-cycle strobe;
- the window is empty after any inactive cycle;
- no stall appears while inactive;
- a newly latched stall always follows an active zero-crossing strobe;
- latched status persists until a clear, and a clear always wins;
- the scaler never reports less than the average.

Only the bench scenarios can show the arithmetic values: averages over a filling window, the exact times-eight results, saturation, and the strict threshold comparison at equality. They also show that each of the four gating conditions blocks a stall on its own, and how the report control affects the pin.

// File: rtl/stall_det_pkg.sv
package stall_det_pkg;

    parameter int SAMPLE_W_DEF    = 10;
    parameter int COUNT_W_DEF     = 11;
    parameter int WIN_DEPTH_DEF   = 4;
    parameter int SCALE_LIMIT_DEF = 500;
    parameter int SCALE_SHIFT_DEF = 3;
    parameter int DECAY_W         = 3;
    parameter logic [DECAY_W-1:0] DECAY_RIPPLE = 3'b111;

    typedef struct packed {
        logic stall;
        logic stl;
        logic fault;
    } stall_status_t;

    function automatic logic detect_gate(
        input logic               mode_sel,
        input logic [DECAY_W-1:0] decay_sel,
        input logic               stall_en,
        input logic               fault_present
    );
        return mode_sel && (decay_sel == DECAY_RIPPLE) && stall_en && !fault_present;
    endfunction

endpackage

// File: rtl/trq_window.sv
module trq_window #(
    parameter int SAMPLE_W = stall_det_pkg::SAMPLE_W_DEF,
    parameter int DEPTH    = stall_det_pkg::WIN_DEPTH_DEF
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                active_i,
    input  logic                stb_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [SAMPLE_W-1:0] avg_o
);
    localparam int SHIFT = $clog2(DEPTH);
    localparam int SUM_W = SAMPLE_W + SHIFT;

    logic [SAMPLE_W-1:0] win_q   [DEPTH];
    logic [SAMPLE_W-1:0] win_nxt [DEPTH];
    logic [SUM_W-1:0]    sum_nxt;

    assign win_nxt[0] = sample_i;
    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_shift
            assign win_nxt[g] = win_q[g-1];
        end
    endgenerate

    always_comb begin
        sum_nxt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sum_nxt = sum_nxt + SUM_W'(win_nxt[i]);
        end
    end

    assign avg_o = SAMPLE_W'(sum_nxt >> SHIFT);

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i) begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= '0;
        end else if (stb_i) begin
            for (int i = 0; i < DEPTH; i++) win_q[i] <= win_nxt[i];
        end
    end

    // R10: an inactive cycle leaves an empty window behind it
    assert_flush_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_i |=> (win_q[0] == '0 && win_q[DEPTH-1] == '0));

endmodule

// File: rtl/trq_scaler.sv
module trq_scaler #(
    parameter int SAMPLE_W = stall_det_pkg::SAMPLE_W_DEF,
    parameter int COUNT_W  = stall_det_pkg::COUNT_W_DEF,
    parameter int LIMIT    = stall_det_pkg::SCALE_LIMIT_DEF,
    parameter int SHIFT    = stall_det_pkg::SCALE_SHIFT_DEF
) (
    input  logic                scale_en_i,
    input  logic [SAMPLE_W-1:0] avg_i,
    output logic [COUNT_W-1:0]  count_o
);
    localparam int PROD_W = COUNT_W + SHIFT;
    localparam logic [PROD_W-1:0] CAP = PROD_W'({COUNT_W{1'b1}});

    logic [PROD_W-1:0] prod;
    logic              small_avg;

    assign small_avg = (32'(avg_i) < LIMIT);
    assign prod      = PROD_W'(avg_i) << SHIFT;

    always_comb begin
        if (scale_en_i && small_avg) begin
            count_o = (prod > CAP) ? CAP[COUNT_W-1:0] : prod[COUNT_W-1:0];
        end else begin
            count_o = COUNT_W'(avg_i);
        end
    end

    // R4 / R5: scaling, saturated or not, never reports below the average
    always_comb begin
        assert_scale_floor_R4: assert (count_o >= COUNT_W'(avg_i));
    end

endmodule

// File: rtl/stall_status_latch.sv
module stall_status_latch
    import stall_det_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          set_i,
    input  logic          clr_i,
    output stall_status_t status_o
);
    stall_status_t st_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            st_q <= '0;
        end else if (set_i) begin
            st_q <= '{stall: 1'b1, stl: 1'b1, fault: 1'b1};
        end
    end

    assign status_o = st_q;

    // R7: a latched stall holds until a clear arrives
    assert_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.stall && !clr_i) |=> (st_q.stall && st_q.stl && st_q.fault));

    // R9: a clear always wins, even against a simultaneous set
    assert_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (st_q == '0));

endmodule

// File: rtl/stall_detector.sv
module stall_detector
    import stall_det_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int COUNT_W  = COUNT_W_DEF
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [SAMPLE_W-1:0] raw_sample_i,
    input  logic                half_cycle_stb_i,
    input  logic                zero_cross_stb_i,
    input  logic                mode_sel_i,
    input  logic [2:0]          decay_sel_i,
    input  logic                stall_en_i,
    input  logic                fault_present_i,
    input  logic [COUNT_W-1:0]  stall_thr_i,
    input  logic                scale_en_i,
    input  logic                report_en_i,
    input  logic                clr_reg_i,
    input  logic                clr_sleep_i,
    output logic [COUNT_W-1:0]  trq_count_o,
    output logic                stall_o,
    output logic                stl_o,
    output logic                fault_o,
    output logic                nfault_o
);
    logic                active;
    logic [SAMPLE_W-1:0] avg;
    logic [COUNT_W-1:0]  count_nxt;
    logic [COUNT_W-1:0]  count_q;
    logic                stall_set;
    logic                clr_any;
    stall_status_t       status;

    assign active = detect_gate(mode_sel_i, decay_sel_i, stall_en_i, fault_present_i);

    trq_window #(.SAMPLE_W(SAMPLE_W), .DEPTH(WIN_DEPTH_DEF)) u_window (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_i (active),
        .stb_i    (half_cycle_stb_i),
        .sample_i (raw_sample_i),
        .avg_o    (avg)
    );

    trq_scaler #(
        .SAMPLE_W (SAMPLE_W),
        .COUNT_W  (COUNT_W),
        .LIMIT    (SCALE_LIMIT_DEF),
        .SHIFT    (SCALE_SHIFT_DEF)
    ) u_scaler (
        .scale_en_i (scale_en_i),
        .avg_i      (avg),
        .count_o    (count_nxt)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q <= '0;
        end else if (active && half_cycle_stb_i) begin
            count_q <= count_nxt;
        end
    end

    assign stall_set = active && zero_cross_stb_i && (count_q < stall_thr_i);
    assign clr_any   = clr_reg_i || clr_sleep_i;

    stall_status_latch u_latch (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .set_i    (stall_set),
        .clr_i    (clr_any),
        .status_o (status)
    );

    assign trq_count_o = count_q;
    assign stall_o     = status.stall;
    assign stl_o       = status.stl;
    assign fault_o     = status.fault;
    assign nfault_o    = !(status.stall && report_en_i);

    // R3: the count moves only after an active half-cycle strobe
    assert_count_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(active && half_cycle_stb_i) |=> $stable(trq_count_o));

    // R1: no new stall while detection is gated off
    assert_gated_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!active && !stall_o) |=> !stall_o);

    // R6: a fresh stall always follows an active zero-crossing strobe
    assert_zc_only_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(stall_o) |-> $past(active && zero_cross_stb_i));

endmodule

// File: tb/stall_detector_tb.sv
module stall_detector_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  sample;
    logic        hc_stb, zc_stb, mode_sel, stall_en, fault_pres;
    logic [2:0]  decay;
    logic [10:0] thr;
    logic        scale_en, rep_en, clr_reg, clr_sleep;
    logic [10:0] trq_count;
    logic        stall, stl, fault, nfault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    stall_detector u_dut (
        .clk_i(clk), .rst_i(rst), .raw_sample_i(sample),
        .half_cycle_stb_i(hc_stb), .zero_cross_stb_i(zc_stb),
        .mode_sel_i(mode_sel), .decay_sel_i(decay), .stall_en_i(stall_en),
        .fault_present_i(fault_pres), .stall_thr_i(thr), .scale_en_i(scale_en),
        .report_en_i(rep_en), .clr_reg_i(clr_reg), .clr_sleep_i(clr_sleep),
        .trq_count_o(trq_count), .stall_o(stall), .stl_o(stl), .fault_o(fault),
        .nfault_o(nfault)
    );

    // {sample[9:0], scale, expected count[10:0]}
    localparam int NVEC = 14;
    localparam logic [21:0] VEC [NVEC] = '{
        {10'd400,  1'b0, 11'd100},
        {10'd400,  1'b0, 11'd200},
        {10'd400,  1'b0, 11'd300},
        {10'd400,  1'b0, 11'd400},
        {10'd800,  1'b0, 11'd500},
        {10'd800,  1'b1, 11'd600},
        {10'd3,    1'b1, 11'd500},
        {10'd1,    1'b1, 11'd2047},
        {10'd1,    1'b1, 11'd1608},
        {10'd2,    1'b1, 11'd8},
        {10'd1023, 1'b0, 11'd256},
        {10'd1023, 1'b1, 11'd512},
        {10'd1023, 1'b1, 11'd767},
        {10'd1023, 1'b1, 11'd1023}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_hc(input logic [9:0] s);
        @(negedge clk);
        sample = s; hc_stb = 1'b1;
        @(negedge clk);
        hc_stb = 1'b0;
    endtask

    task automatic pulse_zc();
        @(negedge clk);
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
    endtask

    task automatic pulse_clr(input bit sleep_src);
        @(negedge clk);
        if (sleep_src) clr_sleep = 1'b1; else clr_reg = 1'b1;
        @(negedge clk);
        clr_sleep = 1'b0; clr_reg = 1'b0;
    endtask

    task automatic enable_all();
        mode_sel = 1'b1; decay = 3'b111; stall_en = 1'b1; fault_pres = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sample = '0; hc_stb = 0; zc_stb = 0;
        mode_sel = 0; decay = 3'b000; stall_en = 0; fault_pres = 0;
        thr = '0; scale_en = 0; rep_en = 1; clr_reg = 0; clr_sleep = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 count", trq_count, 0);
        check("R11 status", {stall, stl, fault}, 0);
        check("R11 nfault", nfault, 1);

        // R2 R4 R5 table walk
        enable_all();
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            scale_en = VEC[i][11];
            pulse_hc(VEC[i][21:12]);
            check($sformatf("R2/R4/R5 vec %0d", i), trq_count, int'(VEC[i][10:0]));
        end

        // R3 hold without strobe
        repeat (5) @(negedge clk);
        check("R3 hold", trq_count, 1023);

        // R1 strobe while disabled leaves count; R10 window flushed
        stall_en = 1'b0;
        pulse_hc(10'd100);
        check("R1 no update inactive", trq_count, 1023);
        enable_all(); scale_en = 1'b0;
        pulse_hc(10'd400);
        check("R10 flushed window", trq_count, 100);

        // R6 equal threshold: no stall; no strobe: no stall
        rep_en = 1'b1;
        thr = 11'd100;
        pulse_zc();
        check("R6 equal no stall", stall, 0);
        thr = 11'd101;
        repeat (4) @(negedge clk);
        check("R6 no strobe no stall", stall, 0);

        // R1 each gate blocks the latch
        mode_sel = 1'b0; pulse_zc(); check("R1 mode gate", stall, 0); enable_all();
        decay = 3'b110;  pulse_zc(); check("R1 decay gate", stall, 0); enable_all();
        stall_en = 1'b0; pulse_zc(); check("R1 enable gate", stall, 0); enable_all();
        fault_pres = 1'b1; pulse_zc(); check("R1 fault gate", stall, 0); enable_all();
        check("R10 count kept", trq_count, 100);

        // R6 R7 R8 latch
        pulse_zc();
        check("R7 status set", {stall, stl, fault}, 7);
        check("R8 nfault low", nfault, 0);
        thr = 11'd0;
        pulse_hc(10'd1000);
        repeat (3) @(negedge clk);
        check("R7 status held", {stall, stl, fault}, 7);
        rep_en = 1'b0;
        #1;
        check("R8 report off", nfault, 1);
        check("R8 bits still set", {stall, stl, fault}, 7);

        // R9 clear via register bit
        rep_en = 1'b1;
        pulse_clr(1'b0);
        check("R9 clr reg", {stall, stl, fault, nfault}, 1);

        // R9 clear via sleep pulse
        thr = 11'd2000;
        pulse_zc();
        check("R6 relatch", stall, 1);
        pulse_clr(1'b1);
        check("R9 clr sleep", {stall, stl, fault, nfault}, 1);

        // R9 clear beats simultaneous stall
        @(negedge clk);
        zc_stb = 1'b1; clr_reg = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0; clr_reg = 1'b0;
        check("R9 clear priority", {stall, stl, fault, nfault}, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule